// File: doc/BRIEF.md
# Battery test sequencer

This block schedules load tests of a backup battery. While the main supply is valid, it closes a test load across the battery for a short pulse. At the end of the pulse it reads a comparator flag that says whether the battery sits below its trip level. The result drives an active-low warning line, modelled as an open-drain pull-down enable. An external analog path provides the load resistor and the comparator. This block only sequences them.

After every power-up, the block waits until the write-protect window has been released. It then always runs a test, even when the warning is already showing. That power-up test is the only test that can set or clear the warning. After it, a long gap of `INTERVAL_TICKS` clock cycles separates each periodic test. A periodic test can only set the warning, never clear it. A supply failure stops any test at once and parks the sequencer. The warning keeps its value through the outage.

The states are `ST_OFF` (supply absent), `ST_ARM` (supply valid, protect window still closed), `ST_PUP_TEST` (forced power-up pulse), `ST_IDLE` (interval count) and `ST_PER_TEST` (periodic pulse). The transitions are:
- `ST_OFF` to `ST_ARM` when the supply is valid.
- `ST_ARM` to `ST_PUP_TEST` when the protect release is seen.
- `ST_PUP_TEST` to `ST_IDLE` at the last pulse cycle.
- `ST_IDLE` to `ST_PER_TEST` at the last gap cycle.
- `ST_PER_TEST` to `ST_IDLE` at the last pulse cycle.
- Any state to `ST_OFF` whenever the supply is not valid.

Top module: `battery_test_seq`

## Requirements
- R1: While reset is applied and right after it, `load_en` is 0 and `warn_n` is 1 (no warning).
- R2: No test starts unless `supply_ok` and `protect_done` are both 1. With `supply_ok` low, or with `supply_ok` high and `protect_done` low, `load_en` stays 0.
- R3: The cycle after `protect_done` is seen high in `ST_ARM`, `load_en` rises. Every test pulse holds `load_en` at 1 for exactly `PULSE_TICKS` cycles.
- R4: The power-up test copies `batt_low`, as sampled on its last pulse cycle, into the warning (1 on `batt_low` drives `warn_n` to 0, 0 drives it to 1). The new value appears in the same cycle that `load_en` falls.
- R5: After each completed test, `load_en` stays 0 for exactly `INTERVAL_TICKS` cycles and then a periodic pulse starts. The gap count restarts from zero after each test, including the power-up test.
- R6: A periodic test that samples `batt_low` = 1 on its last pulse cycle drives `warn_n` to 0 in the cycle `load_en` falls.
- R7: A periodic test that samples `batt_low` = 0 leaves an active warning in place. Only a power-up test can release it.
- R8: `batt_low` is ignored outside the last pulse cycle of a test. Glitches earlier in the pulse or during the gap do not change `warn_n`.
- R9: A cycle with `supply_ok` = 0 forces `load_en` to 0 on the next cycle and abandons the test or gap in progress. No testing occurs while the supply stays low, and `warn_n` keeps its value.
- R10: Every return of the supply followed by the protect release forces a new power-up test, whether or not the warning is active. If it passes, the warning clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Main supply above its valid threshold |
| protect_done | input | 1 | Power-up write-protect window has ended |
| batt_low | input | 1 | Comparator: battery below trip level while loaded |
| load_en | output | 1 | Connects the battery test load |
| warn_n | output | 1 | Battery warning, active low (0 = pull line low) |

## Verification
A wrong state or count in this block shows up at the ports in one of three ways:
- A load pulse one cycle too long or too short.
- A gap between pulses that differs from `INTERVAL_TICKS`.
- A warning edge that does not coincide with the falling edge of `load_en`.

Each of these is visible on the first test after the fault. A latch that confuses power-up and periodic tests shows up only when a passing test meets an active warning. The stimulus therefore sets the warning and follows it with both kinds of passing test. A failure to abort on supply loss shows within one cycle as `load_en` staying high. Comparator glitches are placed away from the sampling cycle, so an early sampling point changes `warn_n` at the end of that same pulse.

// File: rtl/bts_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the battery test sequencer.
package bts_pkg;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_OFF      = 3'd0,  // supply absent, everything parked
        ST_ARM      = 3'd1,  // supply valid, waiting for protect release
        ST_PUP_TEST = 3'd2,  // forced test after power-up
        ST_IDLE     = 3'd3,  // counting the gap between tests
        ST_PER_TEST = 3'd4   // periodic test pulse
    } bts_state_e;

    // Larger of two tick counts, used to size the shared counter.
    function automatic int unsigned bts_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Counter width that can hold values 0 .. n-1 (at least one bit).
    function automatic int unsigned bts_cnt_w(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/bts_counter.sv
`timescale 1ns/1ps
// Shared tick counter: cleared on every state change, counts inside a state.
module bts_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/bts_fsm.sv
`timescale 1ns/1ps
// Sequencing state machine: power-up test, interval, periodic tests, abort.
module bts_fsm
    import bts_pkg::*;
#(
    parameter int unsigned W              = 8,
    parameter int unsigned PULSE_TICKS    = 4,
    parameter int unsigned INTERVAL_TICKS = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         supply_ok,
    input  logic         protect_done,
    input  logic [W-1:0] cnt,
    output logic         cnt_clr,
    output logic         cnt_en,
    output logic         load_en,
    output logic         sample_pup,
    output logic         sample_per
);

    localparam logic [W-1:0] PULSE_LAST = W'(PULSE_TICKS - 1);
    localparam logic [W-1:0] GAP_LAST   = W'(INTERVAL_TICKS - 1);

    bts_state_e st_q;
    bts_state_e st_nxt;

    logic pulse_last;
    logic gap_last;

    assign pulse_last = (cnt == PULSE_LAST);
    assign gap_last   = (cnt == GAP_LAST);

    // Next-state logic. Supply loss overrides every other transition.
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_OFF: begin
                if (supply_ok) st_nxt = ST_ARM;
            end
            ST_ARM: begin
                if (!supply_ok)        st_nxt = ST_OFF;
                else if (protect_done) st_nxt = ST_PUP_TEST;
            end
            ST_PUP_TEST: begin
                if (!supply_ok)      st_nxt = ST_OFF;
                else if (pulse_last) st_nxt = ST_IDLE;
            end
            ST_IDLE: begin
                if (!supply_ok)    st_nxt = ST_OFF;
                else if (gap_last) st_nxt = ST_PER_TEST;
            end
            ST_PER_TEST: begin
                if (!supply_ok)      st_nxt = ST_OFF;
                else if (pulse_last) st_nxt = ST_IDLE;
            end
            default: st_nxt = ST_OFF;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_OFF;
        end else begin
            st_q <= st_nxt;
        end
    end

    // Outputs decoded from the present state.
    always_comb begin
        load_en    = 1'b0;
        sample_pup = 1'b0;
        sample_per = 1'b0;
        cnt_clr    = 1'b1;
        unique case (st_q)
            ST_OFF, ST_ARM: begin
                cnt_clr = 1'b1;
            end
            ST_PUP_TEST: begin
                load_en    = 1'b1;
                sample_pup = supply_ok && pulse_last;
                cnt_clr    = (st_nxt != st_q);
            end
            ST_IDLE: begin
                cnt_clr = (st_nxt != st_q);
            end
            ST_PER_TEST: begin
                load_en    = 1'b1;
                sample_per = supply_ok && pulse_last;
                cnt_clr    = (st_nxt != st_q);
            end
            default: begin
                cnt_clr = 1'b1;
            end
        endcase
        cnt_en = !cnt_clr;
    end

endmodule

// File: rtl/bts_warn_latch.sv
`timescale 1ns/1ps
// Warning latch: the power-up test may set or clear it, a periodic test may only set it.
module bts_warn_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_pup,
    input  logic sample_per,
    input  logic batt_low,
    output logic warn_n
);

    logic warn_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warn_q <= 1'b0;
        end else if (sample_pup) begin
            warn_q <= batt_low;
        end else if (sample_per && batt_low) begin
            warn_q <= 1'b1;
        end
    end

    // Open-drain style: 0 means the line is pulled low (warning).
    assign warn_n = ~warn_q;

endmodule

// File: rtl/battery_test_seq.sv
`timescale 1ns/1ps
// Periodic battery test sequencer, top level.
module battery_test_seq
    import bts_pkg::*;
#(
    parameter int unsigned PULSE_TICKS    = 4,
    parameter int unsigned INTERVAL_TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic protect_done,
    input  logic batt_low,
    output logic load_en,
    output logic warn_n
);

    localparam int unsigned MAX_TICKS = bts_max(PULSE_TICKS, INTERVAL_TICKS);
    localparam int unsigned CNT_W     = bts_cnt_w(MAX_TICKS);

    logic [CNT_W-1:0] cnt;
    logic             cnt_clr;
    logic             cnt_en;
    logic             sample_pup;
    logic             sample_per;

    bts_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .en    (cnt_en),
        .cnt   (cnt)
    );

    bts_fsm #(
        .W              (CNT_W),
        .PULSE_TICKS    (PULSE_TICKS),
        .INTERVAL_TICKS (INTERVAL_TICKS)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_ok    (supply_ok),
        .protect_done (protect_done),
        .cnt          (cnt),
        .cnt_clr      (cnt_clr),
        .cnt_en       (cnt_en),
        .load_en      (load_en),
        .sample_pup   (sample_pup),
        .sample_per   (sample_per)
    );

    bts_warn_latch u_warn (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_pup (sample_pup),
        .sample_per (sample_per),
        .batt_low   (batt_low),
        .warn_n     (warn_n)
    );

endmodule

// File: rtl/bts_checker.sv
`timescale 1ns/1ps
// Port-level checker for the battery test sequencer.
module bts_checker #(
    parameter int unsigned PULSE_TICKS    = 4,
    parameter int unsigned INTERVAL_TICKS = 20
) (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic load_en,
    input logic warn_n
);

    int unsigned run_q;     // consecutive cycles with load_en high
    int unsigned gap_q;     // consecutive cycles with load_en low
    logic        load_d;
    logic        tested_q;  // a test has ended since the supply last came up

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q    <= 0;
            gap_q    <= 0;
            load_d   <= 1'b0;
            tested_q <= 1'b0;
        end else begin
            load_d <= load_en;
            run_q  <= load_en ? run_q + 1 : 0;
            gap_q  <= load_en ? 0 : gap_q + 1;
            if (!supply_ok)              tested_q <= 1'b0;
            else if (load_d && !load_en) tested_q <= 1'b1;
        end
    end

    // R3
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(load_en) && $past(supply_ok)) |-> (run_q == PULSE_TICKS));

    // R3
    pulse_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= PULSE_TICKS);

    // R5
    gap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(load_en) && tested_q) |-> (gap_q == INTERVAL_TICKS));

    // R9
    supply_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !load_en);

    // R4
    warn_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(warn_n) |-> ($past(load_en) && !load_en));

    // R7
    no_periodic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(warn_n) |-> !tested_q);

endmodule

bind battery_test_seq bts_checker #(
    .PULSE_TICKS    (PULSE_TICKS),
    .INTERVAL_TICKS (INTERVAL_TICKS)
) u_bts_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .load_en   (load_en),
    .warn_n    (warn_n)
);

// File: tb/battery_test_seq_tb.sv
`timescale 1ns/1ps
module battery_test_seq_tb;

    localparam int P = 4;
    localparam int I = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic protect_done = 1'b0;
    logic batt_low = 1'b0;
    logic load_en;
    logic warn_n;

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Scoreboard queues: expected outputs at a given cycle count.
    int    q_cyc[$];
    bit    q_le[$];
    bit    q_wn[$];
    string q_tag[$];

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    battery_test_seq #(.PULSE_TICKS(P), .INTERVAL_TICKS(I)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_ok    (supply_ok),
        .protect_done (protect_done),
        .batt_low     (batt_low),
        .load_en      (load_en),
        .warn_n       (warn_n)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic push(input int d, input bit le, input bit wn, input string tag);
        q_cyc.push_back(cyc + d);
        q_le.push_back(le);
        q_wn.push_back(wn);
        q_tag.push_back(tag);
    endtask

    // Monitor: pops due items and compares away from the active edge.
    always @(negedge clk) begin
        while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
            checks++;
            if (q_cyc[0] < cyc) begin
                failures++;
                $display("FAIL %s missed check actual_cycle=%0d expected_cycle=%0d",
                         q_tag[0], cyc, q_cyc[0]);
            end else if (load_en !== q_le[0] || warn_n !== q_wn[0]) begin
                failures++;
                $display("FAIL %s cycle=%0d actual load_en=%b warn_n=%b expected load_en=%b warn_n=%b",
                         q_tag[0], cyc, load_en, warn_n, q_le[0], q_wn[0]);
            end
            void'(q_cyc.pop_front());
            void'(q_le.pop_front());
            void'(q_wn.pop_front());
            void'(q_tag.pop_front());
        end
    end

    // Called with the sequencer in its protect-wait state.
    task automatic pup_test(input bit glitch, input bit low_end,
                            input bit wbefore, input bit wafter, input string tag);
        protect_done = 1'b1;
        batt_low     = glitch;
        push(1, 1'b1, wbefore, "R3");
        push(P, 1'b1, wbefore, "R3");
        push(P + 1, 1'b0, wafter, tag);
        step(P);
        batt_low = low_end;
        step(1);
    endtask

    // Called on the cycle the gap count has just restarted.
    task automatic periodic_test(input bit glitch, input bit low_end,
                                 input bit wbefore, input bit wafter, input string tag);
        batt_low = glitch;
        push(I - 1, 1'b0, wbefore, "R5");
        push(I, 1'b1, wbefore, "R5");
        push(I + P - 1, 1'b1, wbefore, "R3");
        push(I + P, 1'b0, wafter, tag);
        step(I + P - 1);
        batt_low = low_end;
        step(1);
    endtask

    initial begin
        step(3);
        push(0, 1'b0, 1'b1, "R1");
        rst_n = 1'b1;
        push(1, 1'b0, 1'b1, "R1");
        push(4, 1'b0, 1'b1, "R2");           // no supply
        step(5);
        supply_ok = 1'b1;
        push(2, 1'b0, 1'b1, "R2");           // supply but no protect release
        push(7, 1'b0, 1'b1, "R2");
        step(8);
        pup_test(1'b0, 1'b0, 1'b1, 1'b1, "R4");
        periodic_test(1'b0, 1'b0, 1'b1, 1'b1, "R5");
        periodic_test(1'b1, 1'b0, 1'b1, 1'b1, "R8");  // early glitch ignored
        periodic_test(1'b0, 1'b1, 1'b1, 1'b0, "R6");  // warning set
        periodic_test(1'b0, 1'b0, 1'b0, 1'b0, "R7");  // sticky warning
        // R9: supply lost mid-pulse
        push(I, 1'b1, 1'b0, "R5");
        step(I + 1);
        supply_ok    = 1'b0;
        protect_done = 1'b0;
        batt_low     = 1'b1;
        push(1, 1'b0, 1'b0, "R9");
        push(I + P + 5, 1'b0, 1'b0, "R9");
        step(I + P + 5);
        batt_low  = 1'b0;
        supply_ok = 1'b1;
        push(3, 1'b0, 1'b0, "R2");
        step(5);
        pup_test(1'b0, 1'b0, 1'b0, 1'b1, "R10");       // forced test clears warning
        periodic_test(1'b0, 1'b0, 1'b1, 1'b1, "R5");
        supply_ok    = 1'b0;
        protect_done = 1'b0;
        push(2, 1'b0, 1'b1, "R9");
        step(3);
        supply_ok = 1'b1;
        step(3);
        pup_test(1'b0, 1'b1, 1'b1, 1'b0, "R10");       // power-up test sets warning
        periodic_test(1'b0, 1'b0, 1'b0, 1'b0, "R7");
        while (q_cyc.size() > 0) @(negedge clk);
        #1;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule